// File: doc/BRIEF.md
# Addressable LED Pulse-Width Encoder

This block turns a stream of colour bytes into the single-wire waveform that a chain of addressable RGB LEDs expects. Every data bit gets one bit period of fixed length, measured in ticks. The line goes high at the start of each period, and the length of the high pulse tells a one from a zero. Bit periods follow one another with no gap, including across byte boundaries. When the frame is finished, the line stays low for a long latch interval, and the LEDs then take up the new colours.

Software pulses `start_i` and gives the number of LEDs on `led_count_i`. The block then fetches three bytes per LED through a valid/ready port. Upstream should present them in the chain's colour order, green, red, blue for each LED. The block raises `byte_ready_o` for exactly one clock when it needs the next byte, which is the last clock of the current byte's final bit period. The first byte is fetched on the clock right after the start. A byte is taken only on a clock where ready and valid are both high. Upstream can hold valid low for as long as it likes, but if it is low on the clock that ready is offered, the frame ends early and the block goes straight to the latch. A count larger than the real chain only sends surplus data, and the chain ignores it.

Top module: `pxl_wave_tx`

## Requirements
- R1: After reset, and whenever no frame is running, `line_o`, `busy_o` and `byte_ready_o` are low.
- R2: A 1 bit holds the line high for ONE_TICKS ticks (default 7) and a 0 bit for ZERO_TICKS ticks (default 3). A tick is TICK_DIV clocks.
- R3: Every bit period lasts PERIOD_TICKS ticks (default 10), starts with the line high, and is followed at once by the next period, also across byte boundaries.
- R4: Bits go out most significant bit first, and bytes go out in the order they were accepted.
- R5: A frame fetches exactly 3 × `led_count_i` bytes. No ready is offered after the last of them, so surplus upstream bytes stay untaken.
- R6: After the last bit period the line stays low for LATCH_TICKS ticks. `busy_o` stays high until that interval ends, so a full frame keeps busy high for 1 + bits × PERIOD_TICKS × TICK_DIV + LATCH_TICKS × TICK_DIV clocks.
- R7: If valid is low on the clock a byte is requested, no further bits are sent and the latch begins at once.
- R8: `start_i` has no effect while `busy_o` is high.
- R9: `byte_ready_o` is high for a single clock per requested byte and only while busy. A byte is consumed only when ready and valid are both high.
- R10: A start with `led_count_i` = 0 sends no pulses and only runs the latch, for LATCH_TICKS × TICK_DIV clocks of busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-clock request to send a frame |
| led_count_i | input | CNT_W | Number of LEDs in the frame, captured on start |
| byte_data_i | input | 8 | Colour byte from upstream |
| byte_valid_i | input | 1 | Upstream has a byte on `byte_data_i` |
| byte_ready_o | output | 1 | Block takes the byte this clock if valid |
| line_o | output | 1 | Serial data line to the LED chain |
| busy_o | output | 1 | Frame or latch in progress |

## Verification
Two events can fall on the same clock: the byte request and the end of the running bit period. On that clock the block must either load the next byte with no gap, or close the frame and enter the latch. The bench provokes both outcomes by letting the upstream source run dry after a chosen number of bytes, both at the very first fetch and in the middle of a frame. It judges the result from the decoded bit stream, the period between rising edges, the number of ready clocks and the exact busy length. A start strobe issued in the middle of a frame is also checked to leave the bit stream and the frame length unchanged.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
  typedef enum logic [1:0] {
    PX_IDLE  = 2'd0,
    PX_LOAD  = 2'd1,
    PX_BIT   = 2'd2,
    PX_LATCH = 2'd3
  } px_state_e;
endpackage

// File: rtl/pxl_tick_count.sv
// Wrapping counter: advances on step while run is high, clears when run is low.
module pxl_tick_count #(
  parameter int LIMIT = 10,
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         step,
  output logic [W-1:0] count,
  output logic         wrap
);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  assign wrap = run && step && (count == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (!run) begin
      count <= '0;
    end else if (step) begin
      count <= (count == LAST) ? '0 : count + 1'b1;
    end
  end
endmodule

// File: rtl/pxl_shifter.sv
// Byte holder presenting its bits MSB first, with a bit position tracker.
module pxl_shifter #(
  parameter int BYTE_W = 8,
  localparam int IW = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  input  logic              shift,
  output logic              cur_bit,
  output logic              last_bit
);
  logic [BYTE_W-1:0] sh_q;
  logic [IW-1:0]     left_q;

  assign cur_bit  = sh_q[BYTE_W-1];
  assign last_bit = (left_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load) begin
      sh_q   <= din;
      left_q <= IW'(BYTE_W - 1);
    end else if (shift) begin
      sh_q   <= {sh_q[BYTE_W-2:0], 1'b0};
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/pxl_wave_tx.sv
module pxl_wave_tx #(
  parameter int TICK_DIV     = 5,
  parameter int PERIOD_TICKS = 10,
  parameter int ONE_TICKS    = 7,
  parameter int ZERO_TICKS   = 3,
  parameter int LATCH_TICKS  = 448,
  parameter int CNT_W        = 10,
  localparam int RW = CNT_W + 2,
  localparam int TW = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1,
  localparam int LW = (LATCH_TICKS > 1) ? $clog2(LATCH_TICKS) : 1,
  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] led_count_i,
  input  logic [7:0]       byte_data_i,
  input  logic             byte_valid_i,
  output logic             byte_ready_o,
  output logic             line_o,
  output logic             busy_o
);
  import pxl_pkg::*;

  px_state_e      state_q, state_d;
  logic [RW-1:0]  rem_q;
  logic           tick_stb, period_end, latch_end;
  logic [TW-1:0]  tick_q;
  logic [LW-1:0]  latch_cnt;
  logic [DW-1:0]  div_cnt;
  logic           cur_bit, last_bit;
  logic           fetch_pt, need_byte, take, shift;
  logic           in_bit, in_latch;
  logic [RW-1:0]  bytes_total;

  assign in_bit   = (state_q == PX_BIT);
  assign in_latch = (state_q == PX_LATCH);

  pxl_tick_count #(.LIMIT(TICK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(in_bit || in_latch), .step(1'b1),
    .count(div_cnt), .wrap(tick_stb)
  );

  pxl_tick_count #(.LIMIT(PERIOD_TICKS)) u_period (
    .clk(clk), .rst_n(rst_n), .run(in_bit), .step(tick_stb),
    .count(tick_q), .wrap(period_end)
  );

  pxl_tick_count #(.LIMIT(LATCH_TICKS)) u_latch (
    .clk(clk), .rst_n(rst_n), .run(in_latch), .step(tick_stb),
    .count(latch_cnt), .wrap(latch_end)
  );

  assign fetch_pt  = (state_q == PX_LOAD) || (in_bit && period_end && last_bit);
  assign need_byte = fetch_pt && (rem_q != '0);
  assign take      = need_byte && byte_valid_i;
  assign shift     = in_bit && period_end && !last_bit;

  pxl_shifter #(.BYTE_W(8)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(take), .din(byte_data_i), .shift(shift),
    .cur_bit(cur_bit), .last_bit(last_bit)
  );

  assign bytes_total = {2'b00, led_count_i} + {1'b0, led_count_i, 1'b0};

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PX_IDLE:  if (start_i) state_d = (led_count_i == '0) ? PX_LATCH : PX_LOAD;
      PX_LOAD:  state_d = take ? PX_BIT : PX_LATCH;
      PX_BIT:   if (period_end && last_bit) state_d = take ? PX_BIT : PX_LATCH;
      PX_LATCH: if (latch_end) state_d = PX_IDLE;
      default:  state_d = PX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PX_IDLE;
      rem_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == PX_IDLE && start_i) rem_q <= bytes_total;
      else if (take)                     rem_q <= rem_q - 1'b1;
    end
  end

  assign byte_ready_o = need_byte;
  assign busy_o       = (state_q != PX_IDLE);
  assign line_o       = in_bit &&
                        (tick_q < (cur_bit ? TW'(ONE_TICKS) : TW'(ZERO_TICKS)));
endmodule

// File: rtl/pxl_wave_chk.sv
module pxl_wave_chk #(
  parameter int TICK_DIV   = 5,
  parameter int ONE_TICKS  = 7,
  parameter int ZERO_TICKS = 3
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic byte_valid_i,
  input logic byte_ready_o,
  input logic line_o,
  input logic busy_o
);
  logic        line_q;
  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      hi_cnt <= '0;
    end else begin
      line_q <= line_o;
      hi_cnt <= line_o ? hi_cnt + 1'b1 : '0;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!line_o && !byte_ready_o));

  // R9
  ready_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready_o |-> busy_o);

  // R9
  ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready_o |=> !byte_ready_o);

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_q && !line_o) |->
      (hi_cnt == 16'(ONE_TICKS * TICK_DIV) || hi_cnt == 16'(ZERO_TICKS * TICK_DIV)));

  // R6
  latch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> !line_q);

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !$fell(busy_o)) |=> (busy_o || !line_o));
endmodule

bind pxl_wave_tx pxl_wave_chk #(
  .TICK_DIV(TICK_DIV), .ONE_TICKS(ONE_TICKS), .ZERO_TICKS(ZERO_TICKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_valid_i(byte_valid_i),
  .byte_ready_o(byte_ready_o), .line_o(line_o), .busy_o(busy_o)
);

// File: tb/pxl_wave_tx_bench.sv
module pxl_wave_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 2;
  localparam int PER   = 10;
  localparam int ONE   = 7;
  localparam int ZERO  = 3;
  localparam int LAT   = 30;
  localparam int CW    = 4;
  localparam int BITC  = PER * DIV;
  localparam int LATC  = LAT * DIV;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [CW-1:0] led_count_i = '0;
  logic [7:0]    byte_data_i;
  logic          byte_valid_i;
  logic          byte_ready_o, line_o, busy_o;

  logic [7:0] src [0:15];
  int n_avail = 0;
  int idx = 0;

  int n_chk = 0, n_fail = 0;

  // monitor state
  int  cyc = 0, last_rise = 0, last_fall = 0, hi = 0;
  int  nb = 0, per_err = 0, hi_err = 0, rdy_n = 0, tail = -1;
  bit  have_rise = 0, prev_line = 0, prev_busy = 0;
  bit  bits [0:127];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign byte_valid_i = (idx < n_avail);
  assign byte_data_i  = (idx < 16) ? src[idx] : 8'h00;

  pxl_wave_tx #(
    .TICK_DIV(DIV), .PERIOD_TICKS(PER), .ONE_TICKS(ONE),
    .ZERO_TICKS(ZERO), .LATCH_TICKS(LAT), .CNT_W(CW)
  ) u_pxl_wave_tx (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .led_count_i(led_count_i),
    .byte_data_i(byte_data_i), .byte_valid_i(byte_valid_i),
    .byte_ready_o(byte_ready_o), .line_o(line_o), .busy_o(busy_o)
  );

  // upstream source: a byte leaves on a ready & valid edge
  initial forever begin
    @(posedge clk);
    if (byte_ready_o && byte_valid_i) idx <= idx + 1;
  end

  // line decoder sampled between edges
  initial forever begin
    @(negedge clk);
    cyc++;
    if (line_o && !prev_line) begin
      if (have_rise && (cyc - last_rise) != BITC) per_err++;
      have_rise = 1; last_rise = cyc; hi = 1;
    end else if (line_o) begin
      hi++;
    end
    if (!line_o && prev_line) begin
      if (hi == ONE * DIV)       bits[nb] = 1'b1;
      else if (hi == ZERO * DIV) bits[nb] = 1'b0;
      else hi_err++;
      nb++; last_fall = cyc;
    end
    if (byte_ready_o) rdy_n++;
    if (prev_busy && !busy_o && nb > 0) tail = cyc - last_fall;
    prev_line = line_o;
    prev_busy = busy_o;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    nb = 0; per_err = 0; hi_err = 0; rdy_n = 0; tail = -1;
    have_rise = 0; idx = 0;
  endtask

  // runs one frame; optional extra start at busy cycle poke_at
  task automatic run_frame(input int cnt, input int poke_at, output int busy_len);
    @(posedge clk); #1;
    clear_mon();
    led_count_i = CW'(cnt);
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    busy_len = 0;
    while (busy_o && busy_len < 20000) begin
      busy_len++;
      if (busy_len == poke_at) begin
        start_i = 1'b1; led_count_i = CW'(5);
        @(posedge clk); #1;
        start_i = 1'b0;
      end else begin
        @(posedge clk); #1;
      end
    end
    @(posedge clk); #1;
  endtask

  task automatic check_bits(input int nbytes, input string tag);
    int bad = 0;
    for (int k = 0; k < nbytes * 8; k++)
      if (bits[k] != src[k / 8][7 - (k % 8)]) bad++;
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic t_reset();
    chk(!line_o && !busy_o && !byte_ready_o, "R1 reset quiet",
        {line_o, busy_o, byte_ready_o}, 0);
  endtask

  task automatic t_full(input int n);
    int bl;
    n_avail = 3 * n + 2;
    run_frame(n, 0, bl);
    chk(nb == 24 * n, "R4 bit count", nb, 24 * n);
    check_bits(3 * n, "R4 MSB-first order");
    chk(hi_err == 0, "R2 pulse widths", hi_err, 0);
    chk(per_err == 0, "R3 back-to-back periods", per_err, 0);
    chk(idx == 3 * n, "R5 bytes taken", idx, 3 * n);
    chk(rdy_n == 3 * n, "R9 ready clocks", rdy_n, 3 * n);
    chk(bl == 1 + 24 * n * BITC + LATC, "R6 busy length", bl, 1 + 24 * n * BITC + LATC);
    chk(tail >= LATC, "R6 latch low time", tail, LATC);
    chk(!line_o && !busy_o, "R1 idle after frame", {line_o, busy_o}, 0);
  endtask

  task automatic t_underflow(input int have);
    int bl;
    n_avail = have;
    run_frame(3, 0, bl);
    chk(nb == 8 * have, "R7 bits before dry", nb, 8 * have);
    check_bits(have, "R7 data before dry");
    chk(idx == have, "R9 bytes taken", idx, have);
    chk(rdy_n == have + 1, "R9 ready offered", rdy_n, have + 1);
    chk(bl == 1 + 8 * have * BITC + LATC, "R7 busy length", bl, 1 + 8 * have * BITC + LATC);
  endtask

  task automatic t_start_busy();
    int bl;
    n_avail = 16;
    run_frame(1, 100, bl);
    chk(nb == 24, "R8 bits unchanged", nb, 24);
    check_bits(3, "R8 data unchanged");
    chk(idx == 3, "R8 bytes taken", idx, 3);
    chk(bl == 1 + 24 * BITC + LATC, "R8 busy length", bl, 1 + 24 * BITC + LATC);
  endtask

  task automatic t_zero();
    int bl;
    n_avail = 16;
    run_frame(0, 0, bl);
    chk(nb == 0, "R10 no pulses", nb, 0);
    chk(idx == 0 && rdy_n == 0, "R10 no fetch", idx + rdy_n, 0);
    chk(bl == LATC, "R10 latch only", bl, LATC);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) src[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    src[0] = 8'hFF; src[1] = 8'h00; src[2] = 8'hA5;
    t_full(1);
    src[0] = 8'h81; src[1] = 8'h5A; src[2] = 8'h3C;
    src[3] = 8'hC3; src[4] = 8'h0F; src[5] = 8'hF0;
    t_full(2);
    t_underflow(4);
    t_underflow(0);
    src[0] = 8'h96; src[1] = 8'h69; src[2] = 8'h01;
    t_start_busy();
    t_zero();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule